// File: doc/BRIEF.md
# Multi-rate sample interleaving packer

This block sits between the channel sampler and the capture-memory path. Each time the sampler strobes a new sample point, the block takes in a vector of channel levels. It gathers one, two or four of these sample points and emits a single 16-bit event word for the group. A two-bit mode input sets the group size. A wider group gives a higher effective sample rate, but each sample point then contributes fewer channels to the word.

Samples within a word are bit-interleaved rather than placed side by side. For a group of N samples, bit `c*N + k` carries channel `c` of sample `k`, and `k = 0` is the oldest sample. Channel `c` therefore occupies a contiguous run of N bits in time order. Change detection, clustering and storage happen downstream and are not part of this block.

Top module: `ilv_packer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `word_vld` and `word_data` to 0, drops any partly gathered word, and adopts the current `mode_sel`.
- R2: With `mode_sel` = 0, every accepted sample completes a word, and `word_data` equals that sample.
- R3: With `mode_sel` = 1, every second accepted sample completes a word. Bit `2*c + k` holds channel `c` (0..7) of sample `k`, where `k` = 0 is the older sample.
- R4: With `mode_sel` = 2, every fourth accepted sample completes a word. Bit `4*c + k` holds channel `c` (0..3) of sample `k`, where `k` = 0 is the oldest sample.
- R5: Channel bits 8..15 in mode 1, and channel bits 4..15 in mode 2, have no effect on `word_data`.
- R6: `word_vld` is high for exactly the one cycle after the clock edge that accepted a word's final sample. It is low at all other times.
- R7: If `mode_sel` differs from the mode in force while a partial word is held, the partial word is discarded. A sample accepted in that same cycle becomes sample 0 of a new word in the new mode.
- R8: `mode_sel` = 3 behaves exactly as `mode_sel` = 0.
- R9: Idle cycles (with `smp_vld` low) between sample strobes do not disturb the gathering of a word.
- R10: `word_data` holds its last value while `word_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the event-word rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Samples per word: 0 = one, 1 = two, 2 = four, 3 = one |
| smp_data | input | SAMPLE_W (16) | Channel levels of one sample point |
| smp_vld | input | 1 | Strobe marking `smp_data` as a new sample point |
| word_data | output | SAMPLE_W (16) | Packed event word |
| word_vld | output | 1 | One-cycle pulse marking a new `word_data` |

## Verification
The bench feeds each mode groups of samples that each light a single channel or a single sample slot. Examples are one channel group set in only the oldest sample, or each sample carrying a different channel. Each of these patterns lands on a distinct output bit only when the slot index and channel index are woven in the right order, so a swapped stride, reversed age order or contiguous packing gives a visibly different word. Samples with only the out-of-range channels set must yield a zero word, which separates proper channel masking from leakage. Directed sequences switch mode and assert reset halfway through a word, insert idle gaps, and drop a lone sample between words, to tell discarding from merging and holding from updating.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Largest number of sample points merged into one word, and the width of
  // a slot index for it.
  localparam int MAX_SPW = 4;
  localparam int SLOT_W  = $clog2(MAX_SPW);
  localparam int NUM_VAR = SLOT_W + 1;   // group sizes 1, 2 and 4

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X2  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  // Sample points gathered into one word for a given mode.
  function automatic int spw_of(mode_e m);
    case (m)
      MODE_X2: return 2;
      MODE_X4: return 4;
      default: return 1;
    endcase
  endfunction

  // Index of the packing variant (log2 of the group size).
  function automatic int var_of(mode_e m);
    case (m)
      MODE_X2: return 1;
      MODE_X4: return 2;
      default: return 0;
    endcase
  endfunction

  // For output bit position b in a word holding n samples: which sample
  // slot supplies it, and which channel of that sample.
  function automatic int src_slot(int b, int n);
    return b % n;
  endfunction

  function automatic int src_chan(int b, int n);
    return b / n;
  endfunction

endpackage

// File: rtl/ilv_mode_ctrl.sv
module ilv_mode_ctrl
  import ilv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_sel,
  output mode_e eff_mode,
  output logic  mode_chg
);

  mode_e active_q;

  // A request that differs from the mode in force closes the current word.
  assign mode_chg = (mode_sel != active_q);
  assign eff_mode = mode_chg ? mode_sel : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= mode_sel;
    end else if (mode_chg) begin
      active_q <= mode_sel;
    end
  end

  // The mode in force moves only when a change is seen.
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |=> (active_q == $past(active_q)));

  // After a change, the new mode is the one in force.
  assert_mode_taken_R7: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (active_q == $past(mode_sel)));

endmodule

// File: rtl/ilv_collector.sv
module ilv_collector
  import ilv_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [SAMPLE_W-1:0]                smp,
  input  logic                               smp_vld,
  input  logic                               flush,
  input  mode_e                              eff_mode,
  output logic [MAX_SPW-1:0][SAMPLE_W-1:0]   assembled,
  output logic                               word_done
);

  logic [MAX_SPW-1:0][SAMPLE_W-1:0] slots_q;
  logic [MAX_SPW-1:0][SAMPLE_W-1:0] base_slots;
  logic [SLOT_W-1:0]                fill_q;
  logic [SLOT_W-1:0]                base_cnt;
  logic [SLOT_W-1:0]                last_slot;

  // A flush drops the partial word before the incoming sample is placed.
  always_comb begin
    base_cnt   = flush ? '0 : fill_q;
    base_slots = flush ? '0 : slots_q;
    last_slot  = SLOT_W'(spw_of(eff_mode) - 1);
    assembled  = base_slots;
    if (smp_vld) begin
      assembled[base_cnt] = smp;
    end
    word_done  = smp_vld && (base_cnt == last_slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      slots_q <= '0;
    end else if (word_done) begin
      fill_q  <= '0;
      slots_q <= '0;
    end else if (smp_vld) begin
      fill_q  <= base_cnt + SLOT_W'(1);
      slots_q <= assembled;
    end else begin
      fill_q  <= base_cnt;
      slots_q <= base_slots;
    end
  end

  // Without a mode change, the fill level stays below the group size.
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !flush |-> (fill_q <= last_slot));

  // Completing a word leaves the collector empty.
  assert_done_empties_R6: assert property (@(posedge clk) disable iff (rst)
    word_done |=> (fill_q == '0));

  // A flush without a sample leaves nothing gathered.
  assert_flush_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (flush && !smp_vld) |=> (fill_q == '0));

endmodule

// File: rtl/ilv_interleave.sv
module ilv_interleave
  import ilv_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [MAX_SPW-1:0][SAMPLE_W-1:0] assembled,
  input  mode_e                            eff_mode,
  output logic [SAMPLE_W-1:0]              packed_word
);

  logic [NUM_VAR-1:0][SAMPLE_W-1:0] var_word;

  // One weaving network per group size; the mode picks one.
  for (genvar gv = 0; gv < NUM_VAR; gv++) begin : g_var
    localparam int N = 1 << gv;
    always_comb begin
      for (int b = 0; b < SAMPLE_W; b++) begin
        var_word[gv][b] = assembled[src_slot(b, N)][src_chan(b, N)];
      end
    end
  end

  always_comb begin
    case (var_of(eff_mode))
      1:       packed_word = var_word[1];
      2:       packed_word = var_word[2];
      default: packed_word = var_word[0];
    endcase
  end

endmodule

// File: rtl/ilv_packer.sv
module ilv_packer
  import ilv_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_sel,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_vld,
  output logic [SAMPLE_W-1:0] word_data,
  output logic                word_vld
);

  mode_e                            eff_mode;
  logic                             mode_chg;
  logic [MAX_SPW-1:0][SAMPLE_W-1:0] assembled;
  logic                             word_done;
  logic [SAMPLE_W-1:0]              packed_word;

  ilv_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_e'(mode_sel)),
    .eff_mode (eff_mode),
    .mode_chg (mode_chg)
  );

  ilv_collector #(.SAMPLE_W(SAMPLE_W)) u_coll (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp_data),
    .smp_vld   (smp_vld),
    .flush     (mode_chg),
    .eff_mode  (eff_mode),
    .assembled (assembled),
    .word_done (word_done)
  );

  ilv_interleave #(.SAMPLE_W(SAMPLE_W)) u_ilv (
    .assembled   (assembled),
    .eff_mode    (eff_mode),
    .packed_word (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= word_done;
      if (word_done) begin
        word_data <= packed_word;
      end
    end
  end

  // Single-sample modes finish a word on every accepted sample.
  assert_x1_every_R2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=> word_vld);

  // A word pulse always follows an accepted sample.
  assert_vld_cause_R6: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> ($past(smp_vld) && !$past(rst)));

  // Without a pulse, the word output does not move.
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_data));

endmodule

// File: tb/ilv_packer_tb.sv
`timescale 1ns/1ps
module ilv_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode_sel;
  logic [15:0] smp_data;
  logic        smp_vld;
  logic [15:0] word_data;
  logic        word_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ilv_packer #(.SAMPLE_W(16)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .smp_data  (smp_data),
    .smp_vld   (smp_vld),
    .word_data (word_data),
    .word_vld  (word_vld)
  );

  // Stimulus table: [65:64] mode, sample k at [16*k +: 16], k=0 oldest.
  localparam int NVEC = 9;
  localparam logic [65:0] VECS [0:NVEC-1] = '{
    {2'd0, 16'h0000, 16'h0000, 16'h0000, 16'hA5C3},
    {2'd0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
    {2'd1, 16'h0000, 16'h0000, 16'h0000, 16'h00FF},
    {2'd1, 16'h0000, 16'h0000, 16'h00FF, 16'h0000},
    {2'd1, 16'h0000, 16'h0000, 16'h00AA, 16'h0055},
    {2'd2, 16'h0000, 16'h0000, 16'h0000, 16'h000F},
    {2'd2, 16'h0008, 16'h0004, 16'h0002, 16'h0001},
    {2'd2, 16'h000F, 16'h0000, 16'h0000, 16'h0000},
    {2'd1, 16'h0000, 16'h0000, 16'hEE34, 16'hFF12}
  };

  function automatic int n_of(logic [1:0] m);
    if (m == 2'd1) return 2;
    if (m == 2'd2) return 4;
    return 1;
  endfunction

  // Expected word: walk channels, then samples within a channel.
  function automatic logic [15:0] exp_word(logic [1:0] m, logic [63:0] s);
    logic [15:0] w;
    int n;
    n = n_of(m);
    w = '0;
    for (int c = 0; c < 16 / n; c++) begin
      for (int k = 0; k < n; k++) begin
        w[c*n + k] = s[16*k + c];
      end
    end
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one sample, capture outputs just after the accepting edge.
  task automatic send(logic [1:0] m, logic [15:0] d,
                      output logic v, output logic [15:0] w);
    @(negedge clk);
    mode_sel = m;
    smp_data = d;
    smp_vld  = 1'b1;
    @(posedge clk);
    #1;
    v = word_vld;
    w = word_data;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst = 1'b1;
    mode_sel = m;
    smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all reqs): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [15:0] w, prev;
    logic [63:0] s;
    logic [1:0]  m;

    rst = 1'b1;
    mode_sel = 2'd0;
    smp_data = '0;
    smp_vld  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(word_vld == 1'b0, "R1 vld after reset", 32'(word_vld), 32'd0);
    check(word_data == 16'h0, "R1 data after reset", 32'(word_data), 32'd0);

    // Table walk: R2 (mode 0), R3 (mode 1), R4 (mode 2), R5 upper channels
    for (int i = 0; i < NVEC; i++) begin
      m = VECS[i][65:64];
      s = VECS[i][63:0];
      for (int k = 0; k < n_of(m); k++) begin
        send(m, s[16*k +: 16], v, w);
        if (k < n_of(m) - 1) begin
          check(v == 1'b0, "R6 no pulse mid-word", 32'(v), 32'd0);
        end else begin
          check(v == 1'b1, "R6 pulse at word end", 32'(v), 32'd1);
          check(w == exp_word(m, s), "R2/R3/R4/R5 table word", 32'(w),
                32'(exp_word(m, s)));
        end
      end
    end

    // R6: pulse lasts one cycle only
    @(posedge clk);
    #1;
    check(word_vld == 1'b0, "R6 pulse one cycle", 32'(word_vld), 32'd0);

    // R5: only out-of-range channels active gives zero
    for (int k = 0; k < 4; k++) send(2'd2, 16'hFFF0, v, w);
    check(w == 16'h0000, "R5 mode 2 upper channels", 32'(w), 32'd0);
    for (int k = 0; k < 2; k++) send(2'd1, 16'hFF00, v, w);
    check(w == 16'h0000, "R5 mode 1 upper channels", 32'(w), 32'd0);

    // R8: reserved mode acts as single-sample mode
    send(2'd3, 16'h1234, v, w);
    check(v == 1'b1, "R8 reserved mode pulse", 32'(v), 32'd1);
    check(w == 16'h1234, "R8 reserved mode word", 32'(w), 32'h1234);

    // R7: switch from mode 2 to mode 1 after two samples
    send(2'd2, 16'h000F, v, w);
    send(2'd2, 16'h000F, v, w);
    send(2'd1, 16'h0003, v, w);
    check(v == 1'b0, "R7 switch sample starts word", 32'(v), 32'd0);
    send(2'd1, 16'h0081, v, w);
    check(v == 1'b1, "R7 new-mode word pulse", 32'(v), 32'd1);
    check(w == exp_word(2'd1, {32'h0, 16'h0081, 16'h0003}), "R7 partial discarded",
          32'(w), 32'(exp_word(2'd1, {32'h0, 16'h0081, 16'h0003})));

    // R10: lone sample leaves previous word in place
    prev = w;
    send(2'd1, 16'h00F0, v, w);
    check(v == 1'b0 && w == prev, "R10 hold between words", 32'(w), 32'(prev));

    // R9: idle gap inside a word
    send(2'd1, 16'h000F, v, w);
    check(w == exp_word(2'd1, {32'h0, 16'h000F, 16'h00F0}), "R9 after pair",
          32'(w), 32'(exp_word(2'd1, {32'h0, 16'h000F, 16'h00F0})));
    send(2'd1, 16'h0011, v, w);
    repeat (5) @(negedge clk);
    send(2'd1, 16'h0022, v, w);
    check(v == 1'b1 && w == exp_word(2'd1, {32'h0, 16'h0022, 16'h0011}),
          "R9 idle gap word", 32'(w),
          32'(exp_word(2'd1, {32'h0, 16'h0022, 16'h0011})));

    // R1: reset mid-word drops the partial and clears outputs
    send(2'd1, 16'h00FF, v, w);
    do_reset(2'd1);
    @(posedge clk);
    #1;
    check(word_vld == 1'b0 && word_data == 16'h0, "R1 mid-word reset",
          32'(word_data), 32'd0);
    send(2'd1, 16'h0001, v, w);
    check(v == 1'b0, "R1 word restarted", 32'(v), 32'd0);
    send(2'd1, 16'h0000, v, w);
    check(w == 16'h0001, "R1 fresh word after reset", 32'(w), 32'h0001);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule